// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock for an I2C bus master from the fast peripheral clock. A single configuration word carries two fields: a prescale value and a divider value. The prescale value slows the peripheral clock down to an internal tick. The divider value sets how many ticks each half of the SCL period lasts.

The SCL output is active-high release, meaning 1 lets the line float high and 0 pulls it low. The level actually present on the bus comes back in on `sclIn` and passes through a synchroniser. The high half of the period is only counted once that returned level reads high. Because of this, a slow rising edge or a target that holds the clock low (clock stretching) lengthens the period rather than cutting it short.

The generator sits idle with the line released until the configuration word is first written. Each write restarts the clock with a fresh low phase.

Top module: `sclTimingGen`

## Requirements
- R1: After reset, `sclOut` is 1 (line released) and `running` is 0.
- R2: A write on `cfgWr` starts the clock: in the cycle after the write edge, `running` is 1 and `sclOut` is 0.
- R3: Layout of the configuration word. The prescale value P sits in bits [CDF_W-1:0]. The 6-bit divider value D (0 to 63) sits in bits [CDF_W+5:CDF_W], directly above P. CDF_W is a parameter, 2 or 3.
- R4: The internal tick occurs once every P+1 clock cycles. Each low phase lasts (10 + 4·D)·(P+1) clock cycles, and a low phase ends only on a tick.
- R5: The high phase lasts (10 + 4·D)·(P+1) clock cycles, counted from the cycle in which the synchronised line first reads high. With no external hold, SCL is high for that count plus 3 cycles: release, then two synchroniser stages. One full period is therefore 20 + 8·D ticks plus the measured rise delay.
- R6: While the returned line is held low after release, `sclOut` stays 1 and the high count does not start. Holding the line for k cycles past release lengthens the high run by exactly k cycles.
- R7: A write while the clock is running abandons the current phase. The next cycle begins a low phase timed with the new field values.
- R8: Before the first write, activity on `sclIn` has no effect: `sclOut` stays 1 and `running` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Write strobe for the configuration word |
| cfgData | input | CDF_W+6 | Configuration word: divider above prescale |
| sclIn | input | 1 | Level sampled from the SCL line |
| sclOut | output | 1 | SCL drive, 1 releases and 0 pulls low |
| running | output | 1 | Clock has been started |

## Verification
The bench builds two copies of the block. The main copy uses a 3-bit prescale field. With it, the bench runs the fastest setting (P=0, D=0), a mid setting, and the slowest setting (P=7, D=63), measuring low and high runs down to the single cycle. The second copy uses a 2-bit prescale field. The same raw word 7 is written to both copies. Because that word splits into different prescale and divider values in each, the two copies produce different periods, which exposes any error in where the divider field starts. On the main copy, holding the returned line low, rewriting the word mid-period, and toggling the line before the first write cover stretching, restart and the idle state.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

  // Strobes from the phase controller to the counting datapath
  typedef struct packed {
    logic preClr;  // restart the prescaler
    logic phClr;   // restart the phase counter
    logic phInc;   // advance the phase counter
  } sclStrobes_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_WAIT,
    PH_HIGH
  } sclPhase_t;

endpackage

// File: rtl/sclTimingDp.sv
module sclTimingDp
  import sclgen_pkg::*;
#(
  parameter int CDF_W       = 3,
  parameter int SCGD_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int BASE_TICKS  = 20,
  parameter int STEP_TICKS  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWr,
  input  logic [CDF_W+SCGD_W-1:0] cfgData,
  input  sclStrobes_t             strb,
  input  logic                    sclIn,
  output logic                    tick,
  output logic                    phLast,
  output logic                    lineHigh
);

  localparam int HALF_W = SCGD_W + $clog2(STEP_TICKS) + 1;
  localparam logic [HALF_W-1:0] BASE_HALF = HALF_W'(BASE_TICKS / 2);
  localparam logic [HALF_W-1:0] STEP_HALF = HALF_W'(STEP_TICKS / 2);

  logic [CDF_W-1:0]       cdfReg;
  logic [SCGD_W-1:0]      scgdReg;
  logic [CDF_W-1:0]       preCnt;
  logic [HALF_W-1:0]      phCnt;
  logic [HALF_W-1:0]      halfTicks;
  logic [SYNC_STAGES-1:0] syncQ;

  // Divider field sits directly above the prescale field
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cdfReg  <= '0;
      scgdReg <= '0;
    end else if (cfgWr) begin
      {scgdReg, cdfReg} <= cfgData;
    end
  end

  // Prescaler: one tick every cdfReg+1 cycles
  assign tick = (preCnt == cdfReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   preCnt <= '0;
    else if (strb.preClr || tick) preCnt <= '0;
    else                         preCnt <= preCnt + 1'b1;
  end

  // Half-period length in ticks
  assign halfTicks = BASE_HALF + STEP_HALF * HALF_W'(scgdReg);
  assign phLast    = (phCnt == halfTicks - HALF_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           phCnt <= '0;
    else if (strb.phClr) phCnt <= '0;
    else if (strb.phInc) phCnt <= phCnt + 1'b1;
  end

  // Line synchroniser
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= sclIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sclIn};
      end
    end
  endgenerate

  assign lineHigh = syncQ[SYNC_STAGES-1];

endmodule

// File: rtl/sclTimingCtl.sv
module sclTimingCtl
  import sclgen_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWr,
  input  logic        tick,
  input  logic        phLast,
  input  logic        lineHigh,
  output sclStrobes_t strb,
  output logic        sclOut,
  output logic        running,
  output logic        waiting
);

  sclPhase_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    if (cfgWr) begin
      nextState   = PH_LOW;
      strb.preClr = 1'b1;
      strb.phClr  = 1'b1;
    end else begin
      unique case (state)
        PH_IDLE: begin
          strb.preClr = 1'b1;
          strb.phClr  = 1'b1;
        end
        PH_LOW: begin
          if (tick && phLast) begin
            nextState  = PH_WAIT;
            strb.phClr = 1'b1;
          end else if (tick) begin
            strb.phInc = 1'b1;
          end
        end
        PH_WAIT: begin
          strb.preClr = 1'b1;
          strb.phClr  = 1'b1;
          if (lineHigh) nextState = PH_HIGH;
        end
        PH_HIGH: begin
          if (tick && phLast) begin
            nextState  = PH_LOW;
            strb.phClr = 1'b1;
          end else if (tick) begin
            strb.phInc = 1'b1;
          end
        end
        default: nextState = PH_IDLE;
      endcase
    end
  end

  assign sclOut  = (state != PH_LOW);
  assign running = (state != PH_IDLE);
  assign waiting = (state == PH_WAIT);

endmodule

// File: rtl/sclTimingGen.sv
module sclTimingGen
  import sclgen_pkg::*;
#(
  parameter int CDF_W       = 3,
  parameter int SCGD_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int BASE_TICKS  = 20,
  parameter int STEP_TICKS  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWr,
  input  logic [CDF_W+SCGD_W-1:0] cfgData,
  input  logic                    sclIn,
  output logic                    sclOut,
  output logic                    running
);

  sclStrobes_t strb;
  logic tick;
  logic phLast;
  logic lineHigh;
  logic waiting;

  sclTimingDp #(
    .CDF_W(CDF_W), .SCGD_W(SCGD_W), .SYNC_STAGES(SYNC_STAGES),
    .BASE_TICKS(BASE_TICKS), .STEP_TICKS(STEP_TICKS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .strb(strb), .sclIn(sclIn),
    .tick(tick), .phLast(phLast), .lineHigh(lineHigh)
  );

  sclTimingCtl i_ctl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr),
    .tick(tick), .phLast(phLast), .lineHigh(lineHigh),
    .strb(strb), .sclOut(sclOut), .running(running), .waiting(waiting)
  );

endmodule

// File: rtl/sclTimingChk.sv
module sclTimingChk (
  input logic clk,
  input logic rstN,
  input logic cfgWr,
  input logic sclOut,
  input logic running,
  input logic waiting,
  input logic tick,
  input logic lineHigh
);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> sclOut);

  assert_write_starts_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (running && !sclOut));

  assert_low_ends_on_tick_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(running) && !$past(sclOut) && sclOut && !$past(cfgWr)) |-> $past(tick));

  assert_high_after_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(waiting) && !waiting && !$past(cfgWr)) |-> $past(lineHigh));

  assert_stretch_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (waiting && !lineHigh && !cfgWr) |=> (waiting && sclOut));

  assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !cfgWr) |=> (!running && sclOut));

endmodule

bind sclTimingGen sclTimingChk i_chk (
  .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .sclOut(sclOut),
  .running(running), .waiting(waiting), .tick(tick), .lineHigh(lineHigh)
);

// File: tb/test_sclTimingGen.sv
module test_sclTimingGen;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic       rstN;
  logic       cfgWr, cfgWrN;
  logic [8:0] cfgData;
  logic [7:0] cfgDataN;
  logic       holdLow;
  logic       sclOut, running, sclOutN, runningN;
  logic       sclIn, sclInN;

  assign sclIn  = sclOut & ~holdLow;
  assign sclInN = sclOutN;

  sclTimingGen #(.CDF_W(3)) i_sclTimingGen (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .sclIn(sclIn), .sclOut(sclOut), .running(running)
  );

  sclTimingGen #(.CDF_W(2)) i_sclTimingGenNarrow (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWrN), .cfgData(cfgDataN),
    .sclIn(sclInN), .sclOut(sclOutN), .running(runningN)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  task automatic checkVal(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic runLength(input bit narrow, input logic lvl, output int n);
    n = 0;
    while (((narrow ? sclOutN : sclOut) === lvl) && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic writeWide(input logic [8:0] d);
    @(negedge clk);
    cfgData = d;
    cfgWr   = 1'b1;
    @(negedge clk);
    cfgWr   = 1'b0;
  endtask

  task automatic writeNarrow(input logic [7:0] d);
    @(negedge clk);
    cfgDataN = d;
    cfgWrN   = 1'b1;
    @(negedge clk);
    cfgWrN   = 1'b0;
  endtask

  function automatic int phaseLen(int cdf, int scgd);
    return (10 + 4 * scgd) * (cdf + 1);
  endfunction

  task automatic testReset();
    checkVal("R1", "sclOut after reset", sclOut, 1);
    checkVal("R1", "running after reset", running, 0);
    checkVal("R1", "narrow sclOut after reset", sclOutN, 1);
  endtask

  task automatic testIdleIgnore();
    int bad = 0;
    for (int i = 0; i < 8; i++) begin
      holdLow = ~holdLow;
      @(negedge clk);
      if (sclOut !== 1'b1 || running !== 1'b0) bad++;
    end
    holdLow = 1'b0;
    checkVal("R8", "idle cycles disturbed by sclIn", bad, 0);
  endtask

  task automatic testPeriod(int cdf, int scgd);
    int n;
    int dur = phaseLen(cdf, scgd);
    writeWide(9'((scgd << 3) | cdf));
    checkVal("R2", "sclOut right after write", sclOut, 0);
    checkVal("R2", "running right after write", running, 1);
    runLength(1'b0, 1'b0, n);
    checkVal("R4", $sformatf("low run cdf=%0d scgd=%0d", cdf, scgd), n, dur);
    runLength(1'b0, 1'b1, n);
    checkVal("R5", $sformatf("high run cdf=%0d scgd=%0d", cdf, scgd), n, dur + 3);
    runLength(1'b0, 1'b0, n);
    checkVal("R4", $sformatf("second low run cdf=%0d scgd=%0d", cdf, scgd), n, dur);
  endtask

  task automatic testStretch();
    int n;
    int bad = 0;
    writeWide(9'((0 << 3) | 1));
    holdLow = 1'b1;
    runLength(1'b0, 1'b0, n);
    checkVal("R4", "low run before stretch", n, 20);
    for (int i = 0; i < 25; i++) begin
      @(negedge clk);
      if (sclOut !== 1'b1) bad++;
    end
    holdLow = 1'b0;
    checkVal("R6", "sclOut released during hold", bad, 0);
    runLength(1'b0, 1'b1, n);
    checkVal("R6", "stretched high run", 25 + n, 48);
  endtask

  task automatic testRewrite();
    int n;
    writeWide(9'((3 << 3) | 2));
    runLength(1'b0, 1'b0, n);
    repeat (5) @(negedge clk);
    checkVal("R7", "in high phase before rewrite", sclOut, 1);
    writeWide(9'((1 << 3) | 0));
    checkVal("R7", "low right after rewrite", sclOut, 0);
    runLength(1'b0, 1'b0, n);
    checkVal("R7", "low run with new values", n, 14);
    runLength(1'b0, 1'b1, n);
    checkVal("R7", "high run with new values", n, 17);
  endtask

  task automatic testLayout();
    int n;
    writeWide(9'd7);
    runLength(1'b0, 1'b0, n);
    checkVal("R3", "wide word 7 -> P=7 D=0 low run", n, 80);
    writeNarrow(8'd7);
    checkVal("R3", "narrow started", sclOutN, 0);
    runLength(1'b1, 1'b0, n);
    checkVal("R3", "narrow word 7 -> P=3 D=1 low run", n, 56);
    runLength(1'b1, 1'b1, n);
    checkVal("R3", "narrow word 7 high run", n, 59);
  endtask

  initial begin
    rstN = 1'b0; cfgWr = 1'b0; cfgWrN = 1'b0;
    cfgData = '0; cfgDataN = '0; holdLow = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdleIgnore();
    testPeriod(0, 0);
    testPeriod(2, 3);
    testStretch();
    testRewrite();
    testLayout();
    testPeriod(7, 63);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog (R1..R8 run): actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule